// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A register-mapped watchdog that counts down on an enable tick and escalates in two steps. The first time the counter expires, the block raises a level interrupt and starts a new countdown from the programmed load value. If that second countdown also expires before software has cleared the interrupt, the block asserts a sticky reset request. Software keeps the system alive by writing the interrupt-clear register, which acknowledges the interrupt and restarts the count.

A magic-key guard protects the configuration. Until the guard is opened, bus writes to every register other than the guard itself are dropped, so a stray store cannot disarm the watchdog. Reads are combinational from the address. A write is one cycle with request and write asserted.

Top module: `wdg_twostage`

## Requirements
- R1: After reset the load register and the current count both read 0xFFFFFFFF, control reads 0, the guard reads 0 (open), raw and masked status read 0, and both `irq` and `wd_rst` are low.
- R2: Registers sit at these byte addresses: load 0x000 (read/write), current count 0x004 (read only, writes ignored), control 0x008, interrupt clear 0x00C (write only, reads 0), raw status 0x010, masked status 0x014, guard 0xC00. Any other address reads 0.
- R3: Control bit 0 enables counting. While it is set, each cycle with `tick` high lowers the count by one. With the bit clear, or with `tick` low, the count holds.
- R4: A tick that finds the count at zero while the interrupt is clear sets the interrupt and reloads the count from the load register, so the interrupt appears on tick L+1 after the count is loaded with L.
- R5: A tick that finds the count at zero while the interrupt is still set reloads the count and, if control bit 1 is set, asserts `wd_rst`. With control bit 1 clear, no reset is raised and the interrupt stays set.
- R6: Once asserted, `wd_rst` stays high until the block's own reset, whatever is written to the registers.
- R7: Bit 0 of raw status is the interrupt state. Bit 0 of masked status and the `irq` output are that state ANDed with control bit 0.
- R8: A write of any value to the interrupt-clear register clears the interrupt and reloads the count from the load register.
- R9: A write to the load register updates it and places the written value in the count on the same clock edge.
- R10: Writing 0x1ACCE551 to the guard opens it, and writing any other value closes it. The guard reads 1 when closed and 0 when open. While it is closed, writes to all other registers have no effect.
- R11: With the interrupt clear, control set to 3 and the count reading V, `wd_rst` asserts on tick V+L+2, where L is the load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable pulse |
| bus_req | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Masked interrupt level |
| wd_rst | output | 1 | Sticky reset request |

## Verification
The hardest state to reach from the ports is the second expiry, with the interrupt still pending. Whether reset fires depends on one tick being counted exactly right across two full countdowns. The bench sweeps every small load value, with the reset enable on and off, and steps one tick at a time. It records the tick on which the interrupt first appears and the tick on which reset first appears, then compares them with L+1 and 2L+2. A separate run stops partway through a countdown, reads back the count V and checks the V+L+2 arithmetic.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Byte offsets of the register map
   localparam int unsigned OFS_LOAD  = 32'h000;
   localparam int unsigned OFS_COUNT = 32'h004;
   localparam int unsigned OFS_CTRL  = 32'h008;
   localparam int unsigned OFS_ACK   = 32'h00C;
   localparam int unsigned OFS_RAW   = 32'h010;
   localparam int unsigned OFS_MSK   = 32'h014;
   localparam int unsigned OFS_GUARD = 32'hC00;

   // Control word: bit 0 counter/interrupt enable, bit 1 reset enable
   typedef struct packed {
      logic rst_en;
      logic cnt_en;
   } wdg_ctrl_t;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [DATA_W-1:0] KEY = 'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [CNT_W-1:0]  load_q,
   output wdg_ctrl_t         ctrl_q,
   output logic              locked_q,
   output logic              reload_o,
   output logic [CNT_W-1:0]  reload_val_o,
   output logic              ack_o
);

   localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_GUARD = ADDR_W'(OFS_GUARD);
   localparam logic [CNT_W-1:0]  LOAD_INIT = '1;

   logic wr_any;
   logic wr_ok;
   logic hit_load;
   logic hit_ctrl;
   logic hit_ack;
   logic hit_guard;

   always_comb begin
      wr_any    = bus_req & bus_wr;
      wr_ok     = wr_any & ~locked_q;
      hit_load  = wr_ok  && (bus_addr == A_LOAD);
      hit_ctrl  = wr_ok  && (bus_addr == A_CTRL);
      hit_ack   = wr_ok  && (bus_addr == A_ACK);
      hit_guard = wr_any && (bus_addr == A_GUARD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q   <= LOAD_INIT;
         ctrl_q   <= '0;
         locked_q <= 1'b0;
      end else begin
         if (hit_load)
            load_q <= bus_wdata[CNT_W-1:0];
         if (hit_ctrl)
            ctrl_q <= wdg_ctrl_t'(bus_wdata[1:0]);
         if (hit_guard)
            locked_q <= (bus_wdata != KEY);
      end
   end

   // A load write restarts the count with the value being written
   always_comb begin
      reload_o     = hit_load | hit_ack;
      reload_val_o = hit_load ? bus_wdata[CNT_W-1:0] : load_q;
      ack_o        = hit_ack;
   end

   p_locked_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && bus_req && bus_wr && bus_addr != A_GUARD)
      |=> ($stable(load_q) && $stable(ctrl_q)));

   p_key_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == A_GUARD && bus_wdata == KEY)
      |=> !locked_q);

   p_badkey_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == A_GUARD && bus_wdata != KEY)
      |=> locked_q);

endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_en,
   input  logic             rst_en,
   input  logic [CNT_W-1:0] load,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             ack,
   output logic [CNT_W-1:0] count_q,
   output logic             irq_raw_q,
   output logic             wd_rst_q
);

   localparam logic [CNT_W-1:0] CNT_INIT = '1;

   logic step;
   logic at_zero;
   logic expire;

   always_comb begin
      step    = cnt_en & tick & ~reload;
      at_zero = (count_q == '0);
      expire  = step & at_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= CNT_INIT;
      end else if (reload) begin
         count_q <= reload_val;
      end else if (step) begin
         count_q <= at_zero ? load : count_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_raw_q <= 1'b0;
      end else if (ack) begin
         irq_raw_q <= 1'b0;
      end else if (expire) begin
         irq_raw_q <= 1'b1;
      end
   end

   // Second expiry with the interrupt still pending escalates to reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_rst_q <= 1'b0;
      end else if (expire && irq_raw_q && rst_en) begin
         wd_rst_q <= 1'b1;
      end
   end

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && tick && !reload && count_q != '0)
      |=> (count_q == $past(count_q) - 1'b1));

   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !(cnt_en && tick)) |=> $stable(count_q));

   p_first_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && tick && !reload && !ack && count_q == '0 && !irq_raw_q)
      |=> (irq_raw_q && count_q == $past(load)));

   p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst_q) |-> $past(irq_raw_q && rst_en && cnt_en));

   p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_q |=> wd_rst_q);

   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq_raw_q);

   p_reload_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (count_q == $past(reload_val)));

endmodule

// File: rtl/wdg_rdmux.sv
module wdg_rdmux
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  load,
   input  logic [CNT_W-1:0]  count,
   input  wdg_ctrl_t         ctrl,
   input  logic              irq_raw,
   input  logic              locked,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(OFS_MSK);
   localparam logic [ADDR_W-1:0] A_GUARD = ADDR_W'(OFS_GUARD);

   logic [DATA_W-1:0] load_ext;
   logic [DATA_W-1:0] count_ext;

   generate
      if (CNT_W < DATA_W) begin : g_pad
         assign load_ext  = {{(DATA_W-CNT_W){1'b0}}, load};
         assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
      end else begin : g_full
         assign load_ext  = load;
         assign count_ext = count;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_LOAD:  bus_rdata = load_ext;
         A_COUNT: bus_rdata = count_ext;
         A_CTRL:  bus_rdata[1:0] = ctrl;
         A_RAW:   bus_rdata[0] = irq_raw;
         A_MSK:   bus_rdata[0] = irq_raw & ctrl.cnt_en;
         A_GUARD: bus_rdata[0] = locked;
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/wdg_twostage.sv
module wdg_twostage
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [DATA_W-1:0] KEY = 'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wd_rst
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdg_twostage: CNT_W must lie in 2..DATA_W");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("wdg_twostage: ADDR_W must reach the guard register");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("wdg_twostage: DATA_W too narrow");
      end
   endgenerate

   logic [CNT_W-1:0] load_q;
   wdg_ctrl_t        ctrl_q;
   logic             locked_q;
   logic             reload;
   logic [CNT_W-1:0] reload_val;
   logic             ack;
   logic [CNT_W-1:0] count_q;
   logic             irq_raw_q;

   wdg_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .KEY    (KEY)
   ) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_req      (bus_req),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .load_q       (load_q),
      .ctrl_q       (ctrl_q),
      .locked_q     (locked_q),
      .reload_o     (reload),
      .reload_val_o (reload_val),
      .ack_o        (ack)
   );

   wdg_core #(
      .CNT_W (CNT_W)
   ) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cnt_en     (ctrl_q.cnt_en),
      .rst_en     (ctrl_q.rst_en),
      .load       (load_q),
      .reload     (reload),
      .reload_val (reload_val),
      .ack        (ack),
      .count_q    (count_q),
      .irq_raw_q  (irq_raw_q),
      .wd_rst_q   (wd_rst)
   );

   wdg_rdmux #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) i_rdmux (
      .bus_addr  (bus_addr),
      .load      (load_q),
      .count     (count_q),
      .ctrl      (ctrl_q),
      .irq_raw   (irq_raw_q),
      .locked    (locked_q),
      .bus_rdata (bus_rdata)
   );

   assign irq = irq_raw_q & ctrl_q.cnt_en;

   p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_q.cnt_en && irq_raw_q));

endmodule

// File: tb/test_wdg_twostage.sv
module test_wdg_twostage;

   localparam logic [11:0] A_LOAD  = 12'h000;
   localparam logic [11:0] A_COUNT = 12'h004;
   localparam logic [11:0] A_CTRL  = 12'h008;
   localparam logic [11:0] A_ACK   = 12'h00C;
   localparam logic [11:0] A_RAW   = 12'h010;
   localparam logic [11:0] A_MSK   = 12'h014;
   localparam logic [11:0] A_GUARD = 12'hC00;
   localparam logic [31:0] KEY     = 32'h1ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        wd_rst;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdg_twostage i_wdg_twostage (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .wd_rst    (wd_rst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick = 1'b0;
      bus_req = 1'b0;
      bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1;
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0;
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int ki;
      int kr;

      // R1 reset state
      do_reset();
      bread(A_LOAD, rd);  chk("R1 load reset", rd, 32'hFFFFFFFF);
      bread(A_COUNT, rd); chk("R1 count reset", rd, 32'hFFFFFFFF);
      bread(A_CTRL, rd);  chk("R1 ctrl reset", rd, 0);
      bread(A_GUARD, rd); chk("R1 guard open", rd, 0);
      bread(A_RAW, rd);   chk("R1 raw reset", rd, 0);
      bread(A_MSK, rd);   chk("R1 masked reset", rd, 0);
      chk("R1 irq low", {31'b0, irq}, 0);
      chk("R1 wd_rst low", {31'b0, wd_rst}, 0);

      // R2 map: read-only count, write-only ack, holes
      bwrite(A_COUNT, 32'h5);
      bread(A_COUNT, rd); chk("R2 count write ignored", rd, 32'hFFFFFFFF);
      bread(A_ACK, rd);   chk("R2 ack reads zero", rd, 0);
      bread(12'h018, rd); chk("R2 hole reads zero", rd, 0);
      bread(12'h800, rd); chk("R2 hole reads zero", rd, 0);
      bwrite(A_CTRL, 32'h2);
      bread(A_CTRL, rd);  chk("R2 ctrl readback", rd, 2);

      // R9 load write reloads count
      bwrite(A_LOAD, 32'd9);
      bread(A_LOAD, rd);  chk("R9 load readback", rd, 9);
      bread(A_COUNT, rd); chk("R9 count reloaded", rd, 9);

      // R3 enable and tick gating
      bwrite(A_CTRL, 32'h0);
      ticks(3);
      bread(A_COUNT, rd); chk("R3 hold when disabled", rd, 9);
      bwrite(A_CTRL, 32'h1);
      repeat (3) @(negedge clk);
      bread(A_COUNT, rd); chk("R3 hold without tick", rd, 9);
      ticks(3);
      bread(A_COUNT, rd); chk("R3 decrement per tick", rd, 6);

      // R4/R5/R6 sweep over small load values, both reset enables
      for (int l = 0; l <= 6; l++) begin
         for (int re = 0; re <= 1; re++) begin
            do_reset();
            bwrite(A_LOAD, l);
            bwrite(A_CTRL, {30'b0, re[0], 1'b1});
            ki = 0;
            kr = 0;
            for (int k = 1; k <= 2 * l + 4; k++) begin
               ticks(1);
               if (irq && ki == 0) ki = k;
               if (wd_rst && kr == 0) kr = k;
            end
            chk($sformatf("R4 irq tick L=%0d", l), ki, l + 1);
            if (re == 1) begin
               chk($sformatf("R5 reset tick L=%0d", l), kr, 2 * l + 2);
               bwrite(A_CTRL, 32'h0);
               bwrite(A_ACK, 32'h0);
               ticks(2);
               chk($sformatf("R6 reset sticky L=%0d", l), {31'b0, wd_rst}, 1);
            end else begin
               chk($sformatf("R5 no reset when disabled L=%0d", l), kr, 0);
               bread(A_RAW, rd);
               chk($sformatf("R5 irq kept L=%0d", l), rd, 1);
            end
         end
      end

      // R5 count reloaded on second expiry without reset enable
      do_reset();
      bwrite(A_LOAD, 32'd2);
      bwrite(A_CTRL, 32'h1);
      ticks(6);
      bread(A_COUNT, rd); chk("R5 reload at second expiry", rd, 2);
      chk("R5 no reset", {31'b0, wd_rst}, 0);

      // R7 masking
      do_reset();
      bwrite(A_LOAD, 32'd1);
      bwrite(A_CTRL, 32'h1);
      ticks(2);
      bread(A_RAW, rd); chk("R7 raw set", rd, 1);
      bread(A_MSK, rd); chk("R7 masked set", rd, 1);
      chk("R7 irq high", {31'b0, irq}, 1);
      bwrite(A_CTRL, 32'h0);
      bread(A_RAW, rd); chk("R7 raw kept", rd, 1);
      bread(A_MSK, rd); chk("R7 masked off", rd, 0);
      chk("R7 irq low", {31'b0, irq}, 0);

      // R8 interrupt clear reloads
      do_reset();
      bwrite(A_LOAD, 32'd4);
      bwrite(A_CTRL, 32'h1);
      ticks(5);
      bread(A_RAW, rd); chk("R8 irq raised", rd, 1);
      ticks(2);
      bread(A_COUNT, rd); chk("R8 mid count", rd, 2);
      bwrite(A_ACK, 32'hDEADBEEF);
      bread(A_RAW, rd); chk("R8 raw cleared", rd, 0);
      bread(A_COUNT, rd); chk("R8 count reloaded", rd, 4);
      chk("R8 irq low", {31'b0, irq}, 0);

      // R10 guard
      do_reset();
      bwrite(A_GUARD, 32'h1);
      bread(A_GUARD, rd); chk("R10 guard closed", rd, 1);
      bwrite(A_LOAD, 32'd5);
      bread(A_LOAD, rd); chk("R10 load write blocked", rd, 32'hFFFFFFFF);
      bwrite(A_CTRL, 32'h3);
      bread(A_CTRL, rd); chk("R10 ctrl write blocked", rd, 0);
      bwrite(A_GUARD, KEY ^ 32'h1);
      bread(A_GUARD, rd); chk("R10 near key closes", rd, 1);
      bwrite(A_GUARD, KEY);
      bread(A_GUARD, rd); chk("R10 key opens", rd, 0);
      bwrite(A_LOAD, 32'd0);
      bwrite(A_CTRL, 32'h1);
      ticks(1);
      bwrite(A_GUARD, 32'h0);
      bwrite(A_ACK, 32'h0);
      bread(A_RAW, rd); chk("R10 ack blocked", rd, 1);

      // R11 remaining time V+L+2
      do_reset();
      bwrite(A_LOAD, 32'd3);
      bwrite(A_CTRL, 32'h3);
      ticks(2);
      bread(A_COUNT, rd); chk("R11 partial count", rd, 1);
      kr = 0;
      for (int k = 1; k <= 10; k++) begin
         ticks(1);
         if (wd_rst && kr == 0) kr = k;
      end
      chk("R11 reset after V+L+2", kr, 1 + 3 + 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule